// File: doc/BRIEF.md
# PWM-Synchronized ADC Trigger Sequencer

This block issues start-of-conversion requests to four ADC units in step with a PWM carrier. Each ADC owns eight trigger slots. A slot can be armed on a carrier count value, on one of six dead-time event pulses, or on an external network-sync pulse. A slot fires at most once per PWM half cycle. Triggers that arrive while their ADC is still converting wait in a per-ADC queue and are served lowest slot first, so none are lost.

Every finished conversion is written out on that ADC's own write channel, in place of a DMA transfer. The address is the ADC's region base plus the number of results that ADC has already delivered in the current half cycle. At each half-cycle boundary the pointers and the slot state are cleared. When every enabled slot of every ADC has delivered its result, one interrupt pulse is raised for that half cycle. The analog converter itself is outside the block and is modelled as a start/done handshake with a 12-bit data port.

Top module: `adc_trig_seq`

## Requirements
- R1: While reset is held and after it is released with no trigger, `adc_start`, `wr_en` and `irq` are all low.
- R2: A slot whose source code is 0 fires when `pwm_cnt` equals that slot's phase value. Its ADC then receives a one-cycle `adc_start` pulse with `adc_slot` giving the slot index.
- R3: Source codes 1 to 6 select `dt_evt[code-1]`, and source code 7 selects `net_sync`. An event pulse that no enabled slot selects starts no conversion.
- R4: A slot fires at most once between two `half_start` pulses, even if its trigger condition stays true for many cycles.
- R5: A slot whose enable bit is 0 never starts a conversion, and it is not awaited for the interrupt.
- R6: Triggers for an ADC that arrive while that ADC is busy are all kept. Pending slots are started in ascending slot order, one at a time.
- R7: One cycle after `adc_done[i]`, `wr_en[i]` pulses. `wr_data` is the sampled `adc_data`. `wr_addr` is i*8 plus the count of results ADC i has already written in this half cycle, which gives consecutive addresses.
- R8: A `half_start` pulse resets every ADC's write pointer to its region base and re-arms all slots.
- R9: `irq` is a single-cycle pulse, raised at most once per half cycle, in the cycle after the write of the last outstanding enabled slot. It is raised only when at least one slot is enabled and every enabled slot has completed.
- R10: A conversion still running when `half_start` arrives is discarded: its result is not written and it counts toward no interrupt.
- R11: Each ADC has at most one conversion outstanding, and `adc_start` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_start | input | 1 | One-cycle pulse marking a PWM half-cycle boundary |
| pwm_cnt | input | 16 | Current PWM carrier count |
| dt_evt | input | 6 | Dead-time edge event pulses |
| net_sync | input | 1 | Network synchronization pulse |
| cfg_en | input | 32 | Slot enable, bit a*8+s is ADC a, slot s |
| cfg_src | input | 96 | 3-bit source code per slot at bits (a*8+s)*3 |
| cfg_phase | input | 512 | 16-bit phase compare value per slot at bits (a*8+s)*16 |
| adc_start | output | 4 | Start-of-conversion pulse per ADC |
| adc_slot | output | 12 | 3-bit slot index of the running conversion per ADC |
| adc_done | input | 4 | Conversion finished, one cycle per ADC |
| adc_data | input | 48 | 12-bit result per ADC, valid with adc_done |
| wr_en | output | 4 | Result write strobe per ADC channel |
| wr_addr | output | 20 | 5-bit buffer address per ADC channel |
| wr_data | output | 48 | 12-bit result per ADC channel |
| irq | output | 1 | End-of-measurement interrupt pulse |

## Verification
Two things can land in the same cycle: a trigger firing, and a conversion being under way on the same ADC. The directed test provokes this by giving three slots of one ADC the same phase value, then arming a fourth, lower-numbered slot one count later while the first conversion is still running. The result is judged from the order of slot indices recorded in the written data and from the consecutive addresses: the expected order is 0, 2, 3, 5, with no trigger lost. The same kind of collision between the half-cycle boundary and a running conversion is provoked with a long converter latency, and the test expects neither a write nor an interrupt to follow.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // Source code selecting a carrier-count comparison for a slot.
  localparam int unsigned SRC_PHASE = 0;
  // Number of dead-time event inputs.
  localparam int unsigned NUM_DT_DEF = 6;
endpackage

// File: rtl/adc_trig_rst_sync.sv
module adc_trig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/adc_trig_lane.sv
module adc_trig_lane #(
  parameter int SLOTS  = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 5,
  parameter int NUM_DT = 6,
  parameter int LANE   = 0,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int SRC_W  = $clog2(NUM_DT + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     half_start,
  input  logic [CNT_W-1:0]         pwm_cnt,
  input  logic [NUM_DT-1:0]        dt_evt,
  input  logic                     net_sync,
  input  logic [SLOTS-1:0]         slot_en,
  input  logic [SLOTS*SRC_W-1:0]   slot_src,
  input  logic [SLOTS*CNT_W-1:0]   slot_phase,
  input  logic                     adc_done,
  input  logic [DATA_W-1:0]        adc_data,
  output logic                     adc_start,
  output logic [SLOT_W-1:0]        adc_slot,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     lane_done
);
  import adc_trig_pkg::*;

  localparam int PTR_W  = SLOT_W + 1;
  localparam int EVT_N  = 2 ** SRC_W;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(LANE * SLOTS);

  // Event vector indexed by source code; code 0 is handled by the comparator.
  logic [EVT_N-1:0] evt_vec;
  always_comb begin
    evt_vec = '0;
    evt_vec[NUM_DT:1]   = dt_evt;
    evt_vec[NUM_DT + 1] = net_sync;
  end

  logic [SLOTS-1:0] hit;
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [SRC_W-1:0] code;
    assign code   = slot_src[s*SRC_W +: SRC_W];
    assign hit[s] = (code == SRC_W'(SRC_PHASE))
                    ? (pwm_cnt == slot_phase[s*CNT_W +: CNT_W])
                    : evt_vec[code];
  end

  // State registers
  logic [SLOTS-1:0]  fired_q, pending_q, done_q;
  logic              busy_q, stale_q, start_q, wr_en_q;
  logic [SLOT_W-1:0] cur_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  // Next-state signals
  logic [SLOTS-1:0]  fired_d, pending_d, done_d, fire, pend_avail;
  logic              busy_d, stale_d, launch, finish, write;
  logic [SLOT_W-1:0] cur_d, pick;
  logic [PTR_W-1:0]  ptr_d;

  // Lowest pending slot wins.
  always_comb begin
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend_avail[i]) pick = SLOT_W'(i);
    end
  end

  always_comb begin
    pend_avail = half_start ? '0 : pending_q;
    fire       = slot_en & hit & (half_start ? {SLOTS{1'b1}} : ~fired_q);
    fired_d    = (half_start ? '0 : fired_q) | fire;
    launch     = !busy_q && (|pend_avail);
    finish     = busy_q && adc_done;
    write      = finish && !stale_q;

    pending_d = pend_avail | fire;
    if (launch) pending_d[pick] = 1'b0;

    busy_d  = busy_q;
    cur_d   = cur_q;
    stale_d = stale_q;
    if (launch) begin
      busy_d  = 1'b1;
      cur_d   = pick;
      stale_d = 1'b0;
    end else if (finish) begin
      busy_d  = 1'b0;
      stale_d = 1'b0;
    end else if (half_start && busy_q) begin
      stale_d = 1'b1;
    end

    ptr_d  = half_start ? '0 : (write ? ptr_q + PTR_W'(1) : ptr_q);
    done_d = half_start ? '0
             : (done_q | (write ? (SLOTS'(1) << cur_q) : '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q   <= '0;
      pending_q <= '0;
      done_q    <= '0;
      busy_q    <= 1'b0;
      stale_q   <= 1'b0;
      start_q   <= 1'b0;
      wr_en_q   <= 1'b0;
      cur_q     <= '0;
      ptr_q     <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      fired_q   <= fired_d;
      pending_q <= pending_d;
      done_q    <= done_d;
      busy_q    <= busy_d;
      stale_q   <= stale_d;
      start_q   <= launch;
      wr_en_q   <= write;
      cur_q     <= cur_d;
      ptr_q     <= ptr_d;
      if (write) begin
        wr_addr_q <= BASE + ADDR_W'(ptr_q[SLOT_W-1:0]);
        wr_data_q <= adc_data;
      end
    end
  end

  assign adc_start = start_q;
  assign adc_slot  = cur_q;
  assign wr_en     = wr_en_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign lane_done = ((done_q & slot_en) == slot_en);
endmodule

// File: rtl/adc_trig_irq.sv
module adc_trig_irq #(
  parameter int NUM_ADC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_start,
  input  logic [NUM_ADC-1:0] lane_done,
  input  logic               any_en,
  output logic               irq
);
  logic sent_q, irq_q, sent_d, irq_d;

  always_comb begin
    irq_d  = (&lane_done) && any_en && !sent_q && !half_start;
    sent_d = half_start ? 1'b0 : (sent_q | irq_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sent_q <= sent_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int NUM_ADC = 4,
  parameter int SLOTS   = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 12,
  parameter int NUM_DT  = adc_trig_pkg::NUM_DT_DEF,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int SRC_W  = $clog2(NUM_DT + 2),
  localparam int ADDR_W = $clog2(NUM_ADC * SLOTS),
  localparam int TOT    = NUM_ADC * SLOTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      half_start,
  input  logic [CNT_W-1:0]          pwm_cnt,
  input  logic [NUM_DT-1:0]         dt_evt,
  input  logic                      net_sync,
  input  logic [TOT-1:0]            cfg_en,
  input  logic [TOT*SRC_W-1:0]      cfg_src,
  input  logic [TOT*CNT_W-1:0]      cfg_phase,
  output logic [NUM_ADC-1:0]        adc_start,
  output logic [NUM_ADC*SLOT_W-1:0] adc_slot,
  input  logic [NUM_ADC-1:0]        adc_done,
  input  logic [NUM_ADC*DATA_W-1:0] adc_data,
  output logic [NUM_ADC-1:0]        wr_en,
  output logic [NUM_ADC*ADDR_W-1:0] wr_addr,
  output logic [NUM_ADC*DATA_W-1:0] wr_data,
  output logic                      irq
);
  logic               rst_n_int;
  logic [NUM_ADC-1:0] lane_done;

  adc_trig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar a = 0; a < NUM_ADC; a++) begin : g_lane
    adc_trig_lane #(
      .SLOTS  (SLOTS),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .NUM_DT (NUM_DT),
      .LANE   (a)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .half_start (half_start),
      .pwm_cnt    (pwm_cnt),
      .dt_evt     (dt_evt),
      .net_sync   (net_sync),
      .slot_en    (cfg_en[a*SLOTS +: SLOTS]),
      .slot_src   (cfg_src[a*SLOTS*SRC_W +: SLOTS*SRC_W]),
      .slot_phase (cfg_phase[a*SLOTS*CNT_W +: SLOTS*CNT_W]),
      .adc_done   (adc_done[a]),
      .adc_data   (adc_data[a*DATA_W +: DATA_W]),
      .adc_start  (adc_start[a]),
      .adc_slot   (adc_slot[a*SLOT_W +: SLOT_W]),
      .wr_en      (wr_en[a]),
      .wr_addr    (wr_addr[a*ADDR_W +: ADDR_W]),
      .wr_data    (wr_data[a*DATA_W +: DATA_W]),
      .lane_done  (lane_done[a])
    );
  end

  adc_trig_irq #(.NUM_ADC(NUM_ADC)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .half_start (half_start),
    .lane_done  (lane_done),
    .any_en     (|cfg_en),
    .irq        (irq)
  );
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk #(
  parameter int NUM_ADC = 4,
  parameter int SLOTS   = 8,
  parameter int DATA_W  = 12,
  parameter int ADDR_W  = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_ADC*SLOTS-1:0]  cfg_en,
  input logic [NUM_ADC-1:0]        adc_start,
  input logic [NUM_ADC-1:0]        adc_done,
  input logic [NUM_ADC*DATA_W-1:0] adc_data,
  input logic [NUM_ADC-1:0]        wr_en,
  input logic [NUM_ADC*ADDR_W-1:0] wr_addr,
  input logic [NUM_ADC*DATA_W-1:0] wr_data,
  input logic                      irq
);
  // R11: start is a single-cycle pulse on every ADC
  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start & $past(adc_start)) == '0);

  // R7: a write only follows a done in the previous cycle
  p_wr_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en & ~$past(adc_done)) == '0);

  // R9: interrupt lasts one cycle
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: no interrupt without an enabled slot
  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|cfg_en));

  for (genvar i = 0; i < NUM_ADC; i++) begin : g_chk
    // R7: address stays inside the ADC's own region
    p_wr_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |-> (wr_addr[i*ADDR_W +: ADDR_W] >= ADDR_W'(i*SLOTS)) &&
                   (wr_addr[i*ADDR_W +: ADDR_W] <= ADDR_W'(i*SLOTS + SLOTS - 1)));

    // R7: written data equals the converter data of the previous cycle
    p_wr_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |-> wr_data[i*DATA_W +: DATA_W] == $past(adc_data[i*DATA_W +: DATA_W]));
  end
endmodule

bind adc_trig_seq adc_trig_seq_chk #(
  .NUM_ADC (NUM_ADC),
  .SLOTS   (SLOTS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .adc_start (adc_start),
  .adc_done  (adc_done),
  .adc_data  (adc_data),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .irq       (irq)
);

// File: tb/adc_trig_seq_test.sv
module adc_trig_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA  = 4;
  localparam int NS  = 8;
  localparam int CW  = 16;
  localparam int DW  = 12;
  localparam int SW  = 3;
  localparam int AW  = 5;
  localparam int SLW = 3;

  logic clk, rst_n, half_start, net_sync;
  logic [CW-1:0]       pwm_cnt;
  logic [5:0]          dt_evt;
  logic [NA*NS-1:0]    cfg_en;
  logic [NA*NS*SW-1:0] cfg_src;
  logic [NA*NS*CW-1:0] cfg_phase;
  logic [NA-1:0]       adc_start, adc_done, wr_en;
  logic [NA*SLW-1:0]   adc_slot;
  logic [NA*DW-1:0]    adc_data, wr_data;
  logic [NA*AW-1:0]    wr_addr;
  logic                irq;

  adc_trig_seq uut (
    .clk(clk), .rst_n(rst_n), .half_start(half_start), .pwm_cnt(pwm_cnt),
    .dt_evt(dt_evt), .net_sync(net_sync), .cfg_en(cfg_en), .cfg_src(cfg_src),
    .cfg_phase(cfg_phase), .adc_start(adc_start), .adc_slot(adc_slot),
    .adc_done(adc_done), .adc_data(adc_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  int lat [NA];
  int cnt [NA];
  int seq [NA];
  logic [2:0] run_slot [NA];

  // Logs filled by the monitor
  int cyc = 0, n_wr = 0, irq_cnt = 0, irq_cyc = 0, last_wr_cyc = 0, n_start = 0;
  int log_lane [64];
  int log_addr [64];
  int log_slot [64];
  int dt_at [6];
  int net_at;

  // Converter model and monitor, both away from the active edge
  always @(negedge clk) begin
    cyc++;
    for (int a = 0; a < NA; a++) begin
      if (adc_done[a]) adc_done[a] = 1'b0;
      if (cnt[a] > 0) begin
        cnt[a]--;
        if (cnt[a] == 0) begin
          adc_done[a] = 1'b1;
          adc_data[a*DW +: DW] = {2'(a), run_slot[a], 7'(seq[a])};
          seq[a]++;
        end
      end
      if (adc_start[a]) begin
        cnt[a] = lat[a];
        run_slot[a] = adc_slot[a*SLW +: SLW];
        n_start++;
      end
      if (wr_en[a] && n_wr < 64) begin
        log_lane[n_wr] = a;
        log_addr[n_wr] = int'(wr_addr[a*AW +: AW]);
        log_slot[n_wr] = int'(wr_data[a*DW + 7 +: 3]);
        n_wr++;
        last_wr_cyc = cyc;
      end
    end
    if (irq) begin
      irq_cnt++;
      irq_cyc = cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic clear_cfg();
    cfg_en = '0; cfg_src = '0; cfg_phase = '0;
    for (int a = 0; a < NA; a++) lat[a] = 4;
    for (int k = 0; k < 6; k++) dt_at[k] = -1;
    net_at = -1;
  endtask

  task automatic set_slot(input int a, input int s, input bit en, input int src, input int ph);
    cfg_en[a*NS + s] = en;
    cfg_src[(a*NS + s)*SW +: SW] = SW'(src);
    cfg_phase[(a*NS + s)*CW +: CW] = CW'(ph);
  endtask

  task automatic clear_logs();
    n_wr = 0; irq_cnt = 0; n_start = 0; irq_cyc = 0; last_wr_cyc = 0;
  endtask

  task automatic new_half();
    half_start = 1'b1;
    tick();
    half_start = 1'b0;
  endtask

  task automatic sweep(input int len);
    for (int i = 0; i < len; i++) begin
      pwm_cnt = CW'(i);
      for (int k = 0; k < 6; k++) dt_evt[k] = (i == dt_at[k]);
      net_sync = (i == net_at);
      tick();
    end
    pwm_cnt = '1; dt_evt = '0; net_sync = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 adc_start", int'(adc_start), 0);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_phase();
    clear_cfg();
    for (int s = 0; s < 4; s++) set_slot(0, s, 1, 0, 10 + 10*s);
    clear_logs(); new_half(); sweep(60); tick(20);
    chk("R2 starts", n_start, 4);
    chk("R7 writes", n_wr, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R7 addr", log_addr[k], k);
      chk("R2 slot", log_slot[k], k);
    end
    chk("R9 irq count", irq_cnt, 1);
    chk("R9 irq after last write", irq_cyc, last_wr_cyc + 1);
  endtask

  task automatic t_queue();
    clear_cfg();
    lat[1] = 3;
    set_slot(1, 5, 1, 0, 7);
    set_slot(1, 2, 1, 0, 7);
    set_slot(1, 0, 1, 0, 7);
    set_slot(1, 3, 1, 0, 8);
    clear_logs(); new_half(); sweep(20); tick(30);
    chk("R6 writes", n_wr, 4);
    chk("R6 order0", log_slot[0], 0);
    chk("R6 order1", log_slot[1], 2);
    chk("R6 order2", log_slot[2], 3);
    chk("R6 order3", log_slot[3], 5);
    for (int k = 0; k < 4; k++) chk("R7 consecutive addr", log_addr[k], 8 + k);
    chk("R9 irq", irq_cnt, 1);
  endtask

  task automatic t_sources();
    clear_cfg();
    set_slot(2, 0, 1, 4, 0);
    set_slot(2, 1, 1, 7, 0);
    set_slot(2, 2, 1, 1, 0);
    net_at = 10; dt_at[3] = 30; dt_at[0] = 50; dt_at[1] = 70;
    clear_logs(); new_half(); sweep(90); tick(20);
    chk("R3 writes", n_wr, 3);
    chk("R3 net first", log_slot[0], 1);
    chk("R3 dt3 second", log_slot[1], 0);
    chk("R3 dt0 third", log_slot[2], 2);
    chk("R3 addr", log_addr[2], 18);
    chk("R3 lane", log_lane[0], 2);
  endtask

  task automatic t_disabled();
    clear_cfg();
    set_slot(3, 4, 0, 0, 10);
    set_slot(3, 5, 1, 0, 20);
    clear_logs(); new_half(); sweep(40); tick(20);
    chk("R5 writes", n_wr, 1);
    chk("R5 slot", log_slot[0], 5);
    chk("R5 addr", log_addr[0], 24);
    chk("R5 irq", irq_cnt, 1);
  endtask

  task automatic t_full();
    int per_lane [NA];
    bit order_ok;
    clear_cfg();
    for (int a = 0; a < NA; a++) begin
      lat[a] = 8;
      per_lane[a] = 0;
      for (int s = 0; s < NS; s++) set_slot(a, s, 1, 0, 10 + 40*s + 3*a);
    end
    clear_logs(); new_half(); sweep(330); tick(20);
    chk("R7 total writes", n_wr, 32);
    order_ok = 1'b1;
    for (int k = 0; k < n_wr; k++) begin
      if (log_addr[k] != log_lane[k]*NS + per_lane[log_lane[k]]) order_ok = 1'b0;
      if (log_slot[k] != per_lane[log_lane[k]]) order_ok = 1'b0;
      per_lane[log_lane[k]]++;
    end
    chk("R7 address layout", int'(order_ok), 1);
    chk("R9 single irq", irq_cnt, 1);
    chk("R9 irq after last write", irq_cyc, last_wr_cyc + 1);
  endtask

  task automatic t_once_and_reset();
    clear_cfg();
    set_slot(0, 6, 1, 0, 3);
    for (int h = 0; h < 2; h++) begin
      clear_logs(); new_half();
      pwm_cnt = 3; tick(10); pwm_cnt = '1; tick(20);
      chk("R4 one conversion", n_wr, 1);
      chk("R8 pointer at base", log_addr[0], 0);
      chk("R8 irq each half", irq_cnt, 1);
    end
  endtask

  task automatic t_stale();
    clear_cfg();
    lat[0] = 20;
    set_slot(0, 1, 1, 0, 4);
    clear_logs(); new_half(); sweep(9);
    new_half(); tick(40);
    chk("R10 no write", n_wr, 0);
    chk("R10 no irq", irq_cnt, 0);
  endtask

  task automatic t_incomplete();
    clear_cfg();
    set_slot(1, 0, 1, 0, 5);
    set_slot(1, 1, 1, 0, 999);
    clear_logs(); new_half(); sweep(30); tick(20);
    chk("R9 partial writes", n_wr, 1);
    chk("R9 no irq while slot pending", irq_cnt, 0);
  endtask

  initial begin
    rst_n = 1'b0; half_start = 1'b0; net_sync = 1'b0; dt_evt = '0;
    pwm_cnt = '1; adc_done = '0; adc_data = '0;
    for (int a = 0; a < NA; a++) begin
      cnt[a] = 0; seq[a] = 0; run_slot[a] = '0;
    end
    clear_cfg();
    tick(4);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_phase();
    t_queue();
    t_sources();
    t_disabled();
    t_full();
    t_once_and_reset();
    t_stale();
    t_incomplete();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule